// File: doc/BRIEF.md
# Single-Wire Debug Session Sequencer

This controller runs one fixed conversation with a target device over a half-duplex single-wire debug link. It does not serialise bits itself. It commands a separate single-wire transceiver through a byte handshake for transmission and a byte handshake for reception. It can also pull the shared line low directly to wake the target.

A session begins only on a one-cycle trigger. The sequencer first pulls the line low for roughly half a microsecond and then lets go. It waits until the target has released the line, and then waits a guard time of about one hundred microseconds. Next it sends the synchronisation character followed by the system-information read instruction. It collects a fixed number of reply bytes and passes each one on as soon as it arrives.

After the last reply, a second guard time follows. The sequencer then sends the synchronisation character, a control-register store instruction and a data byte that switches the target's debug interface off. It then returns to idle with a done flag raised. If the line never comes back high, or if the replies stop arriving, the sequencer abandons the session and raises an error flag instead.

Reply bytes leave on a valid/ready stream. A byte on `info_data` stays valid and unchanged until `info_ready` is seen high at a clock edge. While that one-byte slot is occupied and not being drained, the sequencer withholds `rx_ready` from the transceiver, so no reply byte is dropped. The command interface follows the same rule: `tx_data` holds while `tx_valid` waits for `tx_ready`.

Top module: `dbg_session_seq`

## Requirements
- R1: After reset, `wake_drive`, `tx_valid`, `rx_ready`, `info_valid`, `done` and `err` are all low. The line is touched and a byte is sent only after `start` is seen high while idle.
- R2: The wake pulse holds `wake_drive` high for exactly WAKE_CYC consecutive cycles. WAKE_CYC = round(CLK_HZ/1000 * WAKE_NS / 1e6), and it is at least 1. The default is 500 ns.
- R3: After the wake pulse, no byte is sent until `line_in` has been observed high. The first byte is then sent no earlier than GUARD_CYC cycles after the line rises, where GUARD_CYC = round(CLK_HZ/1000 * GUARD_US / 1000) with a default of 100 us. Synchroniser latency adds at most a few cycles to this.
- R4: The information request is the two bytes 0x55 then 0xE5, sent in that order on `tx_data`.
- R5: Exactly REPLY_COUNT reply bytes (default 16) are accepted from the transceiver. They are forwarded on `info_data` in arrival order.
- R6: While `info_valid` is high and `info_ready` is low, `info_data` stays stable and `info_valid` stays high. No reply byte is lost under any pattern of `info_ready`.
- R7: After the last reply byte is accepted, no byte is sent for at least GUARD_CYC cycles.
- R8: The disable command is 0x55, then 0xC3 (store opcode 0xC0 with register address 3), then 0x04 (bit 2, the disable bit), sent in that order.
- R9: `done` rises after the final disable byte is accepted and stays high until the next `start`. `done` and `err` are never high together.
- R10: If the line does not read high within TIMEOUT_CYC cycles after the wake pulse, the session aborts to idle with `err` high and no byte sent.
- R11: If fewer than REPLY_COUNT replies arrive within TIMEOUT_CYC cycles of the request, the session aborts with `err` high. The disable command is not sent in that case.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Session trigger, honoured only when idle |
| line_in | input | 1 | Raw level of the debug line (asynchronous) |
| wake_drive | output | 1 | High: force the line low (wake pulse) |
| tx_valid | output | 1 | Command byte offered to the transceiver |
| tx_ready | input | 1 | Transceiver takes the command byte |
| tx_data | output | 8 | Command byte |
| rx_valid | input | 1 | Transceiver holds a received byte |
| rx_ready | output | 1 | Sequencer takes the received byte |
| rx_data | input | 8 | Received byte |
| info_valid | output | 1 | Reply byte available downstream |
| info_ready | input | 1 | Downstream takes the reply byte |
| info_data | output | 8 | Reply byte |
| done | output | 1 | Last session completed |
| err | output | 1 | Last session aborted on a timeout |

## Verification
The embedded properties assume that the transceiver keeps `rx_valid` and `rx_data` unchanged until a byte is taken. They also assume that `start` is a synchronous level. Nothing is assumed about when `tx_ready` or `info_ready` rise. The stimulus changes every input one time unit after the falling clock edge. Its transceiver model holds each reply until the handshake completes. Its target model pulls the line low for a fixed time after waking, or keeps it low forever when a stuck line is being tested.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_RELEASE,
    ST_GUARD_A,
    ST_SEND_REQ,
    ST_COLLECT,
    ST_GUARD_B,
    ST_SEND_OFF
  } seq_state_e;

  localparam logic [7:0] SYNC_BYTE     = 8'h55;
  localparam logic [7:0] INFO_OPCODE   = 8'hE5;
  localparam logic [7:0] STORE_OPCODE  = 8'hC0;
  localparam int         CTRL_REG_ADDR = 3;
  localparam int         OFF_BIT       = 2;

  // script layout: request occupies 0..1, shutdown occupies 2..4
  localparam logic [2:0] REQ_FIRST = 3'd0;
  localparam logic [2:0] REQ_LAST  = 3'd1;
  localparam logic [2:0] OFF_LAST  = 3'd4;

  function automatic logic [7:0] script_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0, 3'd2: b = SYNC_BYTE;
      3'd1:       b = INFO_OPCODE;
      3'd3:       b = STORE_OPCODE | 8'(CTRL_REG_ADDR);
      3'd4:       b = 8'(1 << OFF_BIT);
      default:    b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/dbg_seq_sync.sv
module dbg_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/dbg_seq_delay.sv
module dbg_seq_delay #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_CNT_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) && $past(cnt_q) != '0 |-> cnt_q == $past(cnt_q) - 1'b1); // R3
endmodule

// File: rtl/dbg_seq_replybuf.sv
module dbg_seq_replybuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;
  logic         in_fire;

  assign in_ready  = !full_q || out_ready;
  assign in_fire   = in_valid && in_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (in_fire)        full_q <= 1'b1;
      else if (out_ready) full_q <= 1'b0;
      if (in_fire)        data_q <= in_data;
    end
  end

  AST_INFO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R6
endmodule

// File: rtl/dbg_session_seq.sv
module dbg_session_seq
  import dbg_seq_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int WAKE_NS     = 500,
  parameter int GUARD_US    = 100,
  parameter int REPLY_COUNT = 16,
  parameter int TIMEOUT_CYC = 2_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       line_in,
  output logic       wake_drive,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       info_valid,
  input  logic       info_ready,
  output logic [7:0] info_data,
  output logic       done,
  output logic       err
);
  localparam int WAKE_RAW  = (CLK_HZ / 1000 * WAKE_NS + 500_000) / 1_000_000;
  localparam int GUARD_RAW = (CLK_HZ / 1000 * GUARD_US + 500) / 1000;
  localparam int WAKE_CYC  = (WAKE_RAW < 1) ? 1 : WAKE_RAW;
  localparam int GUARD_CYC = (GUARD_RAW < 1) ? 1 : GUARD_RAW;
  localparam int TOUT_CYC  = (TIMEOUT_CYC < 1) ? 1 : TIMEOUT_CYC;
  localparam int MAX_A     = (WAKE_CYC > GUARD_CYC) ? WAKE_CYC : GUARD_CYC;
  localparam int MAX_LOAD  = (MAX_A > TOUT_CYC) ? MAX_A : TOUT_CYC;
  localparam int CNT_W     = $clog2(MAX_LOAD + 1);
  localparam int RX_W      = $clog2(REPLY_COUNT + 1);
  localparam int SET_W     = $clog2(SYNC_STAGES + 1);

  seq_state_e        state_q, state_d;
  logic [2:0]        idx_q, idx_d;
  logic [RX_W-1:0]   rxcnt_q, rxcnt_d;
  logic [SET_W-1:0]  settle_q, settle_d;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic              tmr_exp;
  logic              line_s;
  logic              finish, fail;
  logic              done_q, err_q;
  logic              collecting, buf_in_ready, rx_fire;

  dbg_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  dbg_seq_delay #(.W(CNT_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(tmr_exp)
  );

  assign collecting = (state_q == ST_COLLECT);
  assign rx_ready   = collecting && buf_in_ready;
  assign rx_fire    = rx_valid && rx_ready;

  dbg_seq_replybuf #(.W(8)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid && collecting), .in_ready(buf_in_ready), .in_data(rx_data),
    .out_valid(info_valid), .out_ready(info_ready), .out_data(info_data)
  );

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    rxcnt_d  = rxcnt_q;
    settle_d = settle_q;
    load     = 1'b0;
    load_val = '0;
    finish   = 1'b0;
    fail     = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_WAKE;
        load     = 1'b1;
        load_val = CNT_W'(WAKE_CYC - 1);
      end
      ST_WAKE: if (tmr_exp) begin
        state_d  = ST_RELEASE;
        settle_d = '0;
        load     = 1'b1;
        load_val = CNT_W'(TOUT_CYC - 1);
      end
      ST_RELEASE: begin
        if (settle_q != SET_W'(SYNC_STAGES)) settle_d = settle_q + 1'b1;
        if (settle_q == SET_W'(SYNC_STAGES) && line_s) begin
          state_d  = ST_GUARD_A;
          load     = 1'b1;
          load_val = CNT_W'(GUARD_CYC - 1);
        end else if (tmr_exp) begin
          state_d = ST_IDLE;
          fail    = 1'b1;
        end
      end
      ST_GUARD_A: if (tmr_exp) begin
        state_d = ST_SEND_REQ;
        idx_d   = REQ_FIRST;
      end
      ST_SEND_REQ: if (tx_ready) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == REQ_LAST) begin
          state_d  = ST_COLLECT;
          rxcnt_d  = '0;
          load     = 1'b1;
          load_val = CNT_W'(TOUT_CYC - 1);
        end
      end
      ST_COLLECT: begin
        if (rx_fire) begin
          rxcnt_d = rxcnt_q + 1'b1;
          if (rxcnt_q == RX_W'(REPLY_COUNT - 1)) begin
            state_d  = ST_GUARD_B;
            load     = 1'b1;
            load_val = CNT_W'(GUARD_CYC - 1);
          end
        end else if (tmr_exp) begin
          state_d = ST_IDLE;
          fail    = 1'b1;
        end
      end
      ST_GUARD_B: if (tmr_exp) state_d = ST_SEND_OFF;
      ST_SEND_OFF: if (tx_ready) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == OFF_LAST) begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      rxcnt_q  <= '0;
      settle_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      rxcnt_q  <= rxcnt_d;
      settle_q <= settle_d;
      if (state_q == ST_IDLE && start) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (finish) done_q <= 1'b1;
      if (fail)   err_q  <= 1'b1;
    end
  end

  assign wake_drive = (state_q == ST_WAKE);
  assign tx_valid   = (state_q == ST_SEND_REQ) || (state_q == ST_SEND_OFF);
  assign tx_data    = script_byte(idx_q);
  assign done       = done_q;
  assign err        = err_q;

  AST_WAKE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_drive) |-> $past(start)); // R1
  AST_QUIET_DURING_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_drive |-> !tx_valid && !rx_ready); // R2
  AST_FIRST_BYTE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_data == SYNC_BYTE); // R4
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R9
  AST_TX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R12
endmodule

// File: tb/dbg_session_seq_test.sv
`timescale 1ns/1ps
module dbg_session_seq_test;
  // 20 MHz model clock for the delay arithmetic: wake = 10 cycles, guard = 2000 cycles
  localparam int EXP_WAKE  = 10;
  localparam int EXP_GUARD = 2000;
  localparam int TOUT      = 3000;
  localparam int NREP      = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic line_in;
  logic wake_drive, tx_valid, rx_ready, info_valid, done, err;
  logic tx_ready = 1'b1, rx_valid = 1'b0, info_ready = 1'b1;
  logic [7:0] tx_data, info_data;
  logic [7:0] rx_data = 8'h00;

  always #2.5 clk = ~clk;

  logic target_low = 1'b0;
  assign line_in = !(wake_drive || target_low);

  dbg_session_seq #(
    .CLK_HZ(20_000_000), .WAKE_NS(500), .GUARD_US(100),
    .REPLY_COUNT(NREP), .TIMEOUT_CYC(TOUT), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .line_in(line_in),
    .wake_drive(wake_drive), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .info_valid(info_valid), .info_ready(info_ready), .info_data(info_data),
    .done(done), .err(err)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // model state and logs
  int cyc = 0;
  int hold_cfg = 30, hold_left = 0;
  bit stuck = 0, bp_mode = 0, rsp_on = 0, line_prev = 1;
  int rsp_n = NREP, rsp_idx = 0;
  logic [7:0] txlog [0:15];
  int txcyc [0:15];
  int txn = 0;
  logic [7:0] infolog [0:31];
  int infon = 0, wake_w = 0, line_rise_cyc = -1, last_rx_cyc = -1;

  always @(negedge clk) begin
    #1;
    rx_valid   = rsp_on && (rsp_idx < rsp_n);
    rx_data    = 8'hA0 + 8'(rsp_idx);
    info_ready = bp_mode ? (cyc % 3 == 0) : 1'b1;
    tx_ready   = bp_mode ? (cyc % 2 == 0) : 1'b1;
    #1;
    if (tx_valid && tx_ready) begin
      if (txn < 16) begin txlog[txn] = tx_data; txcyc[txn] = cyc; end
      txn++;
      if (tx_data == 8'hE5) rsp_on = 1;
    end
    if (rx_valid && rx_ready) begin rsp_idx++; last_rx_cyc = cyc; end
    if (info_valid && info_ready) begin
      if (infon < 32) infolog[infon] = info_data;
      infon++;
    end
    if (wake_drive) wake_w++;
    if (line_in && !line_prev && line_rise_cyc < 0 && wake_w > 0) line_rise_cyc = cyc;
    line_prev = line_in;
    if (wake_drive) hold_left = hold_cfg;
    else if (hold_left > 0) hold_left--;
    target_low = stuck || (hold_left > 0);
    cyc++;
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic prep(input int hold, input bit stk, input int nrep, input bit bp);
    hold_cfg = hold; stuck = stk; rsp_n = nrep; bp_mode = bp;
    rsp_on = 0; rsp_idx = 0; txn = 0; infon = 0; wake_w = 0;
    line_rise_cyc = -1; last_rx_cyc = -1;
  endtask

  task automatic pulse_start();
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_end(input string tag);
    int n = 0;
    while (!(done || err) && n < 20000) begin @(negedge clk); n++; end
    #2;
    chk(n < 20000, tag, "session never ended", n, 20000);
  endtask

  task automatic check_order(input string tag, input int count);
    int bad = 0;
    for (int i = 0; i < count && i < 32; i++)
      if (infolog[i] != 8'hA0 + 8'(i)) bad++;
    chk(bad == 0, tag, "reply bytes out of order", bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk); #2;
    chk(!wake_drive && !tx_valid && !rx_ready && !info_valid, "R1", "drives after reset",
        {wake_drive, tx_valid, rx_ready, info_valid}, 0);
    chk(!done && !err, "R1", "flags after reset", {done, err}, 0);
  endtask

  task automatic t_normal();
    prep(30, 0, NREP, 0);
    pulse_start();
    wait_end("R9");
    chk(done == 1'b1, "R9", "done after session", done, 1);
    chk(err == 1'b0, "R9", "err after good session", err, 0);
    chk(wake_w == EXP_WAKE, "R2", "wake pulse width", wake_w, EXP_WAKE);
    chk(txn == 5, "R8", "bytes sent", txn, 5);
    chk(txlog[0] == 8'h55 && txlog[1] == 8'hE5, "R4", "request bytes",
        {txlog[0], txlog[1]}, 16'h55E5);
    chk(txlog[2] == 8'h55 && txlog[3] == 8'hC3 && txlog[4] == 8'h04, "R8", "disable bytes",
        {txlog[2], txlog[3], txlog[4]}, 24'h55C304);
    chk(infon == NREP, "R5", "reply bytes forwarded", infon, NREP);
    check_order("R5", NREP);
    chk(line_rise_cyc >= 0 && txcyc[0] - line_rise_cyc >= EXP_GUARD &&
        txcyc[0] - line_rise_cyc <= EXP_GUARD + 4, "R3", "gap line high to first byte",
        txcyc[0] - line_rise_cyc, EXP_GUARD);
    chk(txcyc[2] - last_rx_cyc >= EXP_GUARD && txcyc[2] - last_rx_cyc <= EXP_GUARD + 3,
        "R7", "gap last reply to disable", txcyc[2] - last_rx_cyc, EXP_GUARD);
  endtask

  task automatic t_no_trigger();
    prep(30, 0, NREP, 0);
    repeat (300) @(negedge clk);
    #2;
    chk(txn == 0 && wake_w == 0, "R1", "activity without trigger", txn + wake_w, 0);
    chk(done == 1'b1, "R9", "done held in idle", done, 1);
  endtask

  task automatic t_backpressure();
    prep(30, 0, NREP, 1);
    pulse_start();
    wait_end("R6");
    chk(done == 1'b1, "R6", "done under back-pressure", done, 1);
    chk(infon == NREP, "R6", "replies forwarded under back-pressure", infon, NREP);
    check_order("R6", NREP);
    chk(txn == 5 && txlog[1] == 8'hE5 && txlog[3] == 8'hC3 && txlog[4] == 8'h04,
        "R12", "command bytes with stalls", txn, 5);
  endtask

  task automatic t_stuck_line();
    prep(0, 1, NREP, 0);
    pulse_start();
    wait_end("R10");
    chk(err == 1'b1, "R10", "err on stuck line", err, 1);
    chk(done == 1'b0, "R9", "done cleared by new start", done, 0);
    chk(txn == 0, "R10", "bytes sent with stuck line", txn, 0);
    stuck = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_short_reply();
    prep(30, 0, 5, 0);
    pulse_start();
    wait_end("R11");
    chk(err == 1'b1 && done == 1'b0, "R11", "err on missing replies", {err, done}, 2);
    chk(txn == 2, "R11", "disable sent after abort", txn, 2);
    chk(infon == 5, "R11", "partial replies forwarded", infon, 5);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_normal();
    t_no_trigger();
    t_backpressure();
    t_stuck_line();
    t_short_reply();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule